// File: doc/BRIEF.md
# Connection Memory Port Controller with Bulk Fill

This block sits between a host processor and the memories of a time-slot switch. A single 16-bit address selects one of four spaces. The top two address bits choose the space and the low fourteen bits give the offset. Reads of the data memory and the connection memory are passed to external synchronous RAMs, which return data one cycle later. Writes to the connection memory go out on a write port with a valid/ready handshake. A small register space holds a control word and a few auxiliary words that the switch datapath uses.

A bulk-fill engine can initialise the whole connection memory. It writes a two-bit mode pattern into the top two bits of every word and zeros into the other fourteen. When the fill ends, the engine clears its own control bits. A software reset bit freezes all state that software can write, except the reset bit itself. Reads still work while the software reset is set.

Handshake rules:
- **Processor bus.** The host raises `bus_sel` and `bus_stb` with a stable address, data and direction. It holds them until `bus_ack` is seen, then drops `bus_stb`. The block accepts a request on a rising edge where the request is present and `bus_ack` is low. `bus_ack` pulses for one cycle on the edge after acceptance, carrying read data.
- **Back-pressure.** A connection-memory write is accepted only on a handshake with the write port. It is held off entirely while the fill engine owns that port.
- **Write port.** Once `cm_wr_valid` is high, it stays high and `cm_wr_addr` and `cm_wr_data` stay unchanged until `cm_wr_ready` is sampled high. `cm_wr_valid` does not depend on `cm_wr_ready`.

Top module: `cmem_port_ctrl`

## Requirements
- R1: Address bits [15:14] select the space: 2'b11 data memory, 2'b10 connection memory, 2'b01 registers, 2'b00 nothing. Bits [13:0] are the offset passed to the selected memory. A read of space 2'b00 returns zero, and a write to it causes no activity on any port.
- R2: Every accepted access is acknowledged by a single-cycle `bus_ack` on the clock edge after acceptance. A read returns its data on `bus_rdata` in that same cycle. No request is accepted while `bus_ack` is high, and all outputs are zero after reset.
- R3: A processor write to the connection memory is presented on the write port with address equal to the offset and data equal to `bus_wdata`. Valid, address and data stay unchanged until `cm_wr_ready` is sampled high, and the acknowledge follows that handshake.
- R4: Register offset 0 is the control word, with these fields:
  - bit 0: software reset
  - bit 5: fill arm
  - bit 6: fill go
  - bits [8:7]: fill pattern
  - all other bits: plain storage that reads back as written

  The control word resets to zero and is also output on `ctrl_word`.
- R5: A fill starts only on a control write, made while no fill runs and software reset is clear, whose data has bit 0 clear and both bit 5 and bit 6 set. A control write with bit 6 set but bit 5 clear stores bit 6 as 0 and starts nothing.
- R6: A fill writes addresses 0 to 2^CM_AW-1 in ascending order, one word per write-port handshake. Each word is {pattern, 14'b0}. With `cm_wr_ready` held high, `fill_busy` stays high for exactly 2^CM_AW cycles.
- R7: When the last fill word is written, control bits [8:5] clear to zero and `fill_busy` falls. All other control bits keep their values.
- R8: While `fill_busy` is high, a processor connection-memory write is not acknowledged; it completes after the fill ends. Reads of every space, and writes to the register space, proceed during a fill. A control write during a fill leaves bits [8:5] unchanged.
- R9: While software reset is set, reads of all spaces work normally. Writes to the connection memory and the auxiliary registers are acknowledged but change nothing. A control write changes only bit 0.
- R10: A control write that sets bit 0 while software reset is clear has these effects:
  - the control word becomes 16'h0001
  - all auxiliary registers clear
  - any running fill stops at once
- R11: Register offsets 1 to AUX_REGS are read/write auxiliary words, also output on `aux_words` (word k-1 at bits [16k-1:16(k-1)]). Every other register offset reads zero and ignores writes.
- R12: A write to the data memory space is acknowledged and ignored. Data memory contents and the connection memory write port are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| bus_sel | input | 1 | Host select |
| bus_stb | input | 1 | Host strobe, held until acknowledge |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Space select [15:14] and offset [13:0] |
| bus_wdata | input | 16 | Write data |
| bus_ack | output | 1 | Transfer acknowledge, one-cycle pulse |
| bus_rdata | output | 16 | Read data, valid with `bus_ack`, zero otherwise |
| dm_rd_en | output | 1 | Data memory read strobe |
| dm_rd_addr | output | 14 | Data memory read address |
| dm_rd_data | input | 16 | Data memory read data, one cycle after strobe |
| cm_rd_en | output | 1 | Connection memory read strobe |
| cm_rd_addr | output | 14 | Connection memory read address |
| cm_rd_data | input | 16 | Connection memory read data, one cycle after strobe |
| cm_wr_valid | output | 1 | Connection memory write valid |
| cm_wr_ready | input | 1 | Connection memory write ready |
| cm_wr_addr | output | 14 | Connection memory write address |
| cm_wr_data | output | 16 | Connection memory write data |
| fill_busy | output | 1 | Fill engine owns the write port |
| ctrl_word | output | 16 | Current control word |
| aux_words | output | AUX_REGS*16 | Auxiliary words, concatenated |

## Verification
Several properties are checked on every cycle by the assertions:
- `bus_ack` is a one-cycle pulse.
- Write-port valid, address and data stay stable under back-pressure.
- Fill addresses step by one on each handshake, and every fill word has zero low bits.
- No connection-memory write is acknowledged while a fill runs.
- The fill-owned control bits are clear when a fill finishes.
- No fill survives a software reset.
- Auxiliary and control state are frozen while the software reset holds.

Only the bench scenarios show the end-to-end effects:
- The memory contents after a fill, including a processor write that was queued behind it.
- The exact fill duration.
- That reads during a fill or a software reset return correct data.
- That ignored writes really leave the addressed state unchanged.

// File: rtl/cmpc_pkg.sv
package cmpc_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int OFF_W  = 14;

  // control word field positions
  localparam int SRST_BIT = 0;
  localparam int ARM_BIT  = 5;
  localparam int GO_BIT   = 6;
  localparam int PAT_LO   = 7;
  localparam int PAT_HI   = 8;

  localparam logic [DATA_W-1:0] OWN_MASK =
    DATA_W'((1 << ARM_BIT) | (1 << GO_BIT) | (3 << PAT_LO));

  typedef enum logic [1:0] {
    SP_NONE = 2'b00,
    SP_REG  = 2'b01,
    SP_CM   = 2'b10,
    SP_DM   = 2'b11
  } space_e;

  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_DM   = 2'd1,
    SRC_CM   = 2'd2,
    SRC_REG  = 2'd3
  } src_e;

  typedef struct packed {
    logic rd_dm;
    logic rd_cm;
    logic rd_reg;
    logic wr_cm;
    logic wr_reg;
  } acc_t;
endpackage

// File: rtl/cmpc_decode.sv
module cmpc_decode
  import cmpc_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              hit,
  output space_e            space,
  output logic [OFF_W-1:0]  off,
  output acc_t              acc
);
  always_comb begin
    space = space_e'(addr[ADDR_W-1 -: 2]);
    off   = addr[OFF_W-1:0];
    acc   = '0;
    if (hit) begin
      case (space)
        SP_DM:  acc.rd_dm = !wr;
        SP_CM:  begin acc.rd_cm  = !wr; acc.wr_cm  = wr; end
        SP_REG: begin acc.rd_reg = !wr; acc.wr_reg = wr; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cmpc_fill.sv
module cmpc_fill
  import cmpc_pkg::*;
#(
  parameter int CM_AW = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic             ready,
  output logic             busy,
  output logic [OFF_W-1:0] addr,
  output logic             done
);
  localparam logic [CM_AW-1:0] LAST = '1;

  logic [CM_AW-1:0] cnt;

  assign done = busy & ready & (cnt == LAST);
  assign addr = OFF_W'(cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy && ready) begin
      if (cnt == LAST) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R6: each accepted fill word moves the address up by one
  assert_fill_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ready && !abort && cnt != LAST) |=> (busy && cnt == $past(cnt) + 1'b1));

  // R7: the last handshake ends the fill
  assert_fill_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !abort) |=> !busy);
endmodule

// File: rtl/cmpc_regs.sv
module cmpc_regs
  import cmpc_pkg::*;
#(
  parameter int AUX_REGS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [OFF_W-1:0]           off,
  input  logic [DATA_W-1:0]          wdata,
  input  logic                       fill_busy,
  input  logic                       fill_done,
  output logic [DATA_W-1:0]          ctrl,
  output logic [AUX_REGS*DATA_W-1:0] aux_o,
  output logic [DATA_W-1:0]          rdata,
  output logic                       fill_start,
  output logic                       fill_abort
);
  logic                in_srst;
  logic                ctrl_hit;
  logic [DATA_W-1:0]   ctrl_nx;
  logic [DATA_W-1:0]   aux_q [AUX_REGS];

  assign in_srst    = ctrl[SRST_BIT];
  assign ctrl_hit   = (off == '0);
  assign fill_abort = wr_en & ctrl_hit & !in_srst & wdata[SRST_BIT];
  assign fill_start = wr_en & ctrl_hit & !in_srst & !wdata[SRST_BIT] & !fill_busy
                    & wdata[ARM_BIT] & wdata[GO_BIT];

  always_comb begin
    ctrl_nx = ctrl;
    if (wr_en && ctrl_hit) begin
      if (in_srst) begin
        ctrl_nx[SRST_BIT] = wdata[SRST_BIT];
      end else if (wdata[SRST_BIT]) begin
        ctrl_nx = '0;
        ctrl_nx[SRST_BIT] = 1'b1;
      end else if (fill_busy) begin
        ctrl_nx = (wdata & ~OWN_MASK) | (ctrl & OWN_MASK);
      end else begin
        ctrl_nx = wdata;
        if (!wdata[ARM_BIT]) ctrl_nx[GO_BIT] = 1'b0;
      end
    end
    if (fill_done) ctrl_nx = ctrl_nx & ~OWN_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl <= '0;
    else        ctrl <= ctrl_nx;
  end

  for (genvar g = 0; g < AUX_REGS; g++) begin : g_aux
    always_ff @(posedge clk) begin
      if (!rst_n)
        aux_q[g] <= '0;
      else if (fill_abort)
        aux_q[g] <= '0;
      else if (wr_en && !in_srst && off == OFF_W'(g + 1))
        aux_q[g] <= wdata;
    end
    assign aux_o[g*DATA_W +: DATA_W] = aux_q[g];
  end

  always_comb begin
    rdata = '0;
    if (ctrl_hit) rdata = ctrl;
    for (int i = 0; i < AUX_REGS; i++)
      if (off == OFF_W'(i + 1)) rdata = aux_q[i];
  end

  // R9: auxiliary words are frozen while software reset holds
  assert_srst_aux_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_srst && $past(in_srst)) |-> $stable(aux_o));

  // R9: only bit 0 of the control word can move during software reset
  assert_srst_ctrl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_srst && $past(in_srst)) |-> $stable(ctrl[DATA_W-1:1]));
endmodule

// File: rtl/cmem_port_ctrl.sv
module cmem_port_ctrl
  import cmpc_pkg::*;
#(
  parameter int CM_AW    = 14,
  parameter int AUX_REGS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_sel,
  input  logic                       bus_stb,
  input  logic                       bus_wr,
  input  logic [15:0]                bus_addr,
  input  logic [15:0]                bus_wdata,
  output logic                       bus_ack,
  output logic [15:0]                bus_rdata,
  output logic                       dm_rd_en,
  output logic [13:0]                dm_rd_addr,
  input  logic [15:0]                dm_rd_data,
  output logic                       cm_rd_en,
  output logic [13:0]                cm_rd_addr,
  input  logic [15:0]                cm_rd_data,
  output logic                       cm_wr_valid,
  input  logic                       cm_wr_ready,
  output logic [13:0]                cm_wr_addr,
  output logic [15:0]                cm_wr_data,
  output logic                       fill_busy,
  output logic [15:0]                ctrl_word,
  output logic [AUX_REGS*16-1:0]     aux_words
);
  logic              ack_q;
  logic              ack_cmwr_q;
  src_e              src_q;
  logic [DATA_W-1:0] reg_rd_q;
  logic              hit;
  space_e            space;
  logic [OFF_W-1:0]  off;
  acc_t              acc;
  logic              in_srst;
  logic              proc_cm_wr;
  logic              stall;
  logic              accept;
  logic [OFF_W-1:0]  fill_addr;
  logic              fill_done;
  logic              fill_start;
  logic              fill_abort;
  logic [DATA_W-1:0] reg_rdata;
  logic [1:0]        pattern;

  assign hit = bus_sel & bus_stb & !ack_q;

  cmpc_decode u_dec (
    .addr  (bus_addr),
    .wr    (bus_wr),
    .hit   (hit),
    .space (space),
    .off   (off),
    .acc   (acc)
  );

  assign in_srst    = ctrl_word[SRST_BIT];
  assign proc_cm_wr = acc.wr_cm & !in_srst;
  assign stall      = proc_cm_wr & (fill_busy | !cm_wr_ready);
  assign accept     = hit & !stall;
  assign pattern    = ctrl_word[PAT_HI:PAT_LO];

  cmpc_fill #(.CM_AW(CM_AW)) u_fill (
    .clk   (clk),
    .rst_n (rst_n),
    .start (fill_start),
    .abort (fill_abort),
    .ready (cm_wr_ready),
    .busy  (fill_busy),
    .addr  (fill_addr),
    .done  (fill_done)
  );

  cmpc_regs #(.AUX_REGS(AUX_REGS)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (accept & acc.wr_reg),
    .off        (off),
    .wdata      (bus_wdata),
    .fill_busy  (fill_busy),
    .fill_done  (fill_done),
    .ctrl       (ctrl_word),
    .aux_o      (aux_words),
    .rdata      (reg_rdata),
    .fill_start (fill_start),
    .fill_abort (fill_abort)
  );

  // connection memory write port: fill engine has priority
  assign cm_wr_valid = fill_busy | proc_cm_wr;
  assign cm_wr_addr  = fill_busy ? fill_addr : off;
  assign cm_wr_data  = fill_busy ? {pattern, {OFF_W{1'b0}}} : bus_wdata;

  assign dm_rd_en   = accept & acc.rd_dm;
  assign dm_rd_addr = off;
  assign cm_rd_en   = accept & acc.rd_cm;
  assign cm_rd_addr = off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q      <= 1'b0;
      ack_cmwr_q <= 1'b0;
      src_q      <= SRC_ZERO;
      reg_rd_q   <= '0;
    end else begin
      ack_q      <= accept;
      ack_cmwr_q <= accept & proc_cm_wr;
      if (accept) begin
        if (acc.rd_dm)       src_q <= SRC_DM;
        else if (acc.rd_cm)  src_q <= SRC_CM;
        else if (acc.rd_reg) src_q <= SRC_REG;
        else                 src_q <= SRC_ZERO;
        reg_rd_q <= reg_rdata;
      end
    end
  end

  assign bus_ack = ack_q;

  always_comb begin
    bus_rdata = '0;
    if (ack_q) begin
      case (src_q)
        SRC_DM:  bus_rdata = dm_rd_data;
        SRC_CM:  bus_rdata = cm_rd_data;
        SRC_REG: bus_rdata = reg_rd_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  // R2: acknowledge is a single-cycle pulse
  assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);

  // R3: write port holds its word under back-pressure
  assert_wr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_wr_valid && !cm_wr_ready) |=>
      (cm_wr_valid && $stable(cm_wr_addr) && $stable(cm_wr_data)));

  // R6: every fill word carries zeros in its low bits
  assert_fill_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_busy |-> (cm_wr_valid && cm_wr_data[OFF_W-1:0] == '0));

  // R7: owned control bits are clear once a fill finishes normally
  assert_done_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fill_busy) && !ctrl_word[SRST_BIT]) |-> (ctrl_word[PAT_HI:ARM_BIT] == '0));

  // R8: no processor connection write is acknowledged from inside a fill
  assert_no_wr_in_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack && ack_cmwr_q) |-> !$past(fill_busy));

  // R10: a fill never runs while software reset is set
  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[SRST_BIT] |-> !fill_busy);

  // R12: a data memory write never reaches the connection write port
  assert_dm_wr_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && bus_wr && space == SP_DM && !fill_busy) |-> !cm_wr_valid);
endmodule

// File: tb/cmem_port_ctrl_tb.sv
module cmem_port_ctrl_tb;
  localparam int CM_AW = 6;
  localparam int DEPTH = 1 << CM_AW;
  localparam int AUXN  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, stb = 1'b0, bwr = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic bus_ack;
  logic [15:0] bus_rdata;
  logic dm_rd_en, cm_rd_en, cm_wr_valid, fill_busy;
  logic [13:0] dm_rd_addr, cm_rd_addr, cm_wr_addr;
  logic [15:0] dm_q, cm_q, cm_wr_data, ctrl_word;
  logic [AUXN*16-1:0] aux_words;
  logic cm_wr_ready = 1'b1;
  logic rdy_rand = 1'b0;

  int n_chk = 0, n_bad = 0;
  int hs_cnt = 0, fill_hs = 0, seq_bad = 0;
  logic [5:0] fill_exp = '0;
  logic [15:0] cmem [DEPTH];
  logic [15:0] exp_mem [DEPTH];
  logic [15:0] exp_aux [AUXN];
  logic [15:0] exp_ctrl;
  logic [15:0] r;
  int lat;

  always #5 clk = ~clk;

  cmem_port_ctrl #(.CM_AW(CM_AW), .AUX_REGS(AUXN)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_stb(stb), .bus_wr(bwr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .dm_rd_en(dm_rd_en), .dm_rd_addr(dm_rd_addr), .dm_rd_data(dm_q),
    .cm_rd_en(cm_rd_en), .cm_rd_addr(cm_rd_addr), .cm_rd_data(cm_q),
    .cm_wr_valid(cm_wr_valid), .cm_wr_ready(cm_wr_ready), .cm_wr_addr(cm_wr_addr),
    .cm_wr_data(cm_wr_data), .fill_busy(fill_busy), .ctrl_word(ctrl_word),
    .aux_words(aux_words)
  );

  function automatic logic [15:0] dm_fn(input logic [13:0] a);
    return {a[7:0] ^ 8'h3C, 2'b10, a[13:8]};
  endfunction

  // memory models
  always @(posedge clk) begin
    if (cm_wr_valid && cm_wr_ready) begin
      cmem[cm_wr_addr[5:0]] <= cm_wr_data;
      hs_cnt <= hs_cnt + 1;
      if (fill_busy) begin
        fill_hs <= fill_hs + 1;
        if (cm_wr_addr != {8'd0, fill_exp}) seq_bad <= seq_bad + 1;
        fill_exp <= fill_exp + 1'b1;
      end
    end else if (!fill_busy) begin
      fill_exp <= '0;
    end
    if (cm_rd_en) cm_q <= cmem[cm_rd_addr[5:0]];
    if (dm_rd_en) dm_q <= dm_fn(dm_rd_addr);
  end

  always @(negedge clk) cm_wr_ready <= rdy_rand ? (($urandom % 3) != 0) : 1'b1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic [15:0] a, input logic [15:0] d,
                      output logic [15:0] rd, output int l);
    @(negedge clk);
    sel = 1'b1; stb = 1'b1; bwr = w; addr = a; wdata = d;
    l = 0;
    do begin
      @(negedge clk);
      l++;
    end while (!bus_ack);
    rd = bus_rdata;
    sel = 1'b0; stb = 1'b0; bwr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] a, input logic [15:0] exp);
    logic [15:0] v;
    int l;
    xfer(1'b0, a, 16'h0, v, l);
    chk(tag, v, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int h0, f0, c;
    void'($urandom(32'd20240611));
    for (int i = 0; i < AUXN; i++) exp_aux[i] = '0;
    exp_ctrl = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R4 reset state
    chk("R2 reset ack", bus_ack, 0);
    chk("R2 reset rdata", bus_rdata, 0);
    chk("R4 reset ctrl", ctrl_word, 0);
    chk("R6 reset busy", fill_busy, 0);
    chk("R3 reset valid", cm_wr_valid, 0);

    // R1 / R2 data memory reads
    for (int i = 0; i < 6; i++) begin
      logic [13:0] o = 14'($urandom);
      xfer(1'b0, {2'b11, o}, 16'h0, r, lat);
      chk("R1 dm read", r, dm_fn(o));
      chk("R2 latency", lat, 1);
    end

    // R1 empty space
    h0 = hs_cnt;
    rd_chk("R1 space00 read", 16'h1234, 16'h0);
    xfer(1'b1, 16'h0010, 16'hFFFF, r, lat);
    chk("R1 space00 write quiet", hs_cnt, h0);

    // R12 data memory write ignored
    xfer(1'b1, 16'hC003, 16'h5A5A, r, lat);
    chk("R12 dm write quiet", hs_cnt, h0);
    rd_chk("R12 dm unchanged", 16'hC003, dm_fn(14'd3));

    // R3 connection writes under random back-pressure
    rdy_rand = 1'b1;
    for (int i = 0; i < 10; i++) begin
      logic [5:0] o = 6'(i * 7 + 1);
      logic [15:0] v = 16'($urandom);
      xfer(1'b1, {2'b10, 8'd0, o}, v, r, lat);
      exp_mem[o] = v;
      chk("R3 ack after handshake", (lat >= 1), 1);
    end
    for (int i = 0; i < 10; i++) begin
      logic [5:0] o = 6'(i * 7 + 1);
      rd_chk("R3 cm readback", {2'b10, 8'd0, o}, exp_mem[o]);
    end

    // R4 / R11 registers
    exp_ctrl = 16'($urandom) & ~16'h01E1;
    xfer(1'b1, 16'h4000, exp_ctrl, r, lat);
    rd_chk("R4 ctrl readback", 16'h4000, exp_ctrl);
    chk("R4 ctrl port", ctrl_word, exp_ctrl);
    for (int i = 0; i < AUXN; i++) begin
      exp_aux[i] = 16'($urandom);
      xfer(1'b1, 16'h4000 | 16'(i + 1), exp_aux[i], r, lat);
    end
    for (int i = 0; i < AUXN; i++)
      rd_chk("R11 aux readback", 16'h4000 | 16'(i + 1), exp_aux[i]);
    chk("R11 aux port", aux_words[31:16], exp_aux[1]);
    xfer(1'b1, 16'h4000 | 16'(AUXN + 1), 16'hABCD, r, lat);
    rd_chk("R11 unmapped reg", 16'h4000 | 16'(AUXN + 1), 16'h0);
    rd_chk("R11 high reg", 16'h7FFF, 16'h0);

    // R5 go without arm
    h0 = hs_cnt;
    xfer(1'b1, 16'h4000, 16'h0140, r, lat);
    @(negedge clk);
    chk("R5 no fill", fill_busy, 0);
    rd_chk("R5 go dropped", 16'h4000, 16'h0100);
    chk("R5 no writes", hs_cnt, h0);

    // R6 / R7 / R8 fill with random ready
    f0 = fill_hs;
    xfer(1'b1, 16'h4000, 16'h0D60, r, lat);
    chk("R5 fill started", fill_busy, 1);
    rd_chk("R8 ctrl read during fill", 16'h4000, 16'h0D60);
    xfer(1'b0, 16'h8009, 16'h0, r, lat);
    chk("R8 cm read during fill", lat, 1);
    xfer(1'b1, 16'h4000, 16'h0C00, r, lat);
    rd_chk("R8 owned bits kept", 16'h4000, 16'h0D60);
    xfer(1'b1, 16'h8005, 16'hBEEF, r, lat);
    chk("R8 write stalled", (lat > 1), 1);
    chk("R7 fill ended", fill_busy, 0);
    chk("R6 fill count", fill_hs - f0, DEPTH);
    chk("R6 fill order", seq_bad, 0);
    rd_chk("R7 ctrl after fill", 16'h4000, 16'h0C00);
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = 16'h8000;
    exp_mem[5] = 16'hBEEF;
    for (int i = 0; i < DEPTH; i++)
      rd_chk("R6 fill contents", {2'b10, 8'd0, 6'(i)}, exp_mem[i]);

    // R6 exact duration with ready held high
    rdy_rand = 1'b0;
    @(negedge clk);
    xfer(1'b1, 16'h4000, 16'h00E0, r, lat);
    c = 0;
    while (fill_busy) begin c++; @(negedge clk); end
    chk("R6 fill cycles", c, DEPTH);
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = 16'h4000;
    rd_chk("R6 fill2 word5", 16'h8005, 16'h4000);
    rd_chk("R6 fill2 word63", 16'h803F, 16'h4000);
    rd_chk("R7 ctrl cleared", 16'h4000, 16'h0000);
    chk("R6 fill order 2", seq_bad, 0);

    // random mixed traffic
    exp_ctrl = '0;
    for (int k = 0; k < 120; k++) begin
      int op = int'($urandom % 5);
      int ai = int'($urandom % AUXN);
      case (op)
        0: begin
          exp_aux[ai] = 16'($urandom);
          xfer(1'b1, 16'h4000 | 16'(ai + 1), exp_aux[ai], r, lat);
        end
        1: rd_chk("R11 rand aux", 16'h4000 | 16'(ai + 1), exp_aux[ai]);
        2: begin
          exp_ctrl = 16'($urandom) & ~16'h01E1;
          xfer(1'b1, 16'h4000, exp_ctrl, r, lat);
          rd_chk("R4 rand ctrl", 16'h4000, exp_ctrl);
        end
        3: begin
          logic [13:0] o = 14'($urandom);
          rd_chk("R1 rand dm", {2'b11, o}, dm_fn(o));
        end
        default: begin
          logic [5:0] o = 6'($urandom);
          rd_chk("R1 rand cm", {2'b10, 8'd0, o}, exp_mem[o]);
        end
      endcase
    end

    // R9 / R10 software reset
    xfer(1'b1, 16'h4001, 16'h1234, r, lat);
    xfer(1'b1, 16'h4000, 16'h0C01, r, lat);
    rd_chk("R10 ctrl on entry", 16'h4000, 16'h0001);
    rd_chk("R10 aux cleared", 16'h4001, 16'h0000);
    chk("R10 aux port", aux_words, '0);
    h0 = hs_cnt;
    xfer(1'b1, 16'h8003, 16'h7777, r, lat);
    chk("R9 cm write acked", lat, 1);
    chk("R9 cm write quiet", hs_cnt, h0);
    rd_chk("R9 cm unchanged", 16'h8003, exp_mem[3]);
    xfer(1'b1, 16'h4002, 16'h5555, r, lat);
    rd_chk("R9 aux ignored", 16'h4002, 16'h0000);
    rd_chk("R9 dm readable", 16'hC0AB, dm_fn(14'h00AB));
    xfer(1'b1, 16'h4000, 16'hFFFF, r, lat);
    rd_chk("R9 only bit0", 16'h4000, 16'h0001);
    chk("R9 no fill", fill_busy, 0);
    xfer(1'b1, 16'h4000, 16'hFFFE, r, lat);
    rd_chk("R9 leave reset", 16'h4000, 16'h0000);
    xfer(1'b1, 16'h4002, 16'h5555, r, lat);
    rd_chk("R11 aux after reset", 16'h4002, 16'h5555);

    // R10 abort of running fill
    f0 = fill_hs;
    xfer(1'b1, 16'h4000, 16'h0160, r, lat);
    xfer(1'b1, 16'h4000, 16'h0001, r, lat);
    chk("R10 fill stopped", fill_busy, 0);
    chk("R10 fill partial", (fill_hs - f0 < DEPTH), 1);
    rd_chk("R10 ctrl abort", 16'h4000, 16'h0001);
    xfer(1'b1, 16'h4000, 16'h0000, r, lat);
    rd_chk("R9 reset cleared", 16'h4000, 16'h0000);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule